// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Software Force

This block gathers fifteen interrupt request lines from on-chip peripherals and external pins, latches each rising edge into a pending register, and presents the most urgent enabled request to the processor. The request is presented as a 4-bit level and as an 8-bit trap type. Source n owns bit n of every register, and bit 0 is never used. Source 1 is the correctable memory error. Sources 2 and 3 are the serial ports, 4 to 7 are external pins, 8 and 9 are the timers, and 10 to 15 are spare.

Software reaches four word registers through a simple register bus. The enable register is at byte offset 0x0, the pending register at 0x4 (read-only), the force register at 0x8, and a write-one-to-clear register at 0xC. The priority is fixed by source number: the higher the number, the more urgent the request. When the processor takes the interrupt it pulses an acknowledge input with the level it is serving. The controller then drops that source's pending and forced state.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the enable, pending and force registers read 0, and the level and trap type outputs are 0.
- R2: A rising edge on request line n (1..15) sets pending bit n on the next clock. The bit stays set until it is cleared or acknowledged, and a line held high does not set it again without a new edge.
- R3: A write to offset 0x0 loads the enable register from write-data bits 15:1. Source n takes part in arbitration only while enable bit n is 1. Bit 0 and bits 31:16 read 0.
- R4: A write to offset 0x8 loads the force register from bits 15:1, and the register reads back at 0x8. A forced source that is enabled requests exactly as a pending one does.
- R5: A write to offset 0xC with bit n set clears pending bit n and force bit n. Bits written as 0 leave the other sources unchanged, and a read of 0xC returns 0.
- R6: Writes to offset 0x4 have no effect on the pending register.
- R7: The level output equals the highest source number n whose enable bit is 1 and whose pending or force bit is 1. The level is 0 when there is no such source.
- R8: The trap type equals level + 0x10 when the level is nonzero, and 0 when the level is 0.
- R9: When the acknowledge input is high, the given level n (1..15) clears pending bit n and force bit n on that clock. An acknowledge of level 0 changes nothing.
- R10: A rising edge on line n in the same cycle as a clear or an acknowledge of source n leaves pending bit n set.
- R11: Request line 0 and bit 0 of every write are ignored. Pending bit 0 and force bit 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 16 | Request lines, bit n is source n, bit 0 unused |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, same cycle as the strobe, 0 when not reading |
| ack_i | input | 1 | Processor acknowledge strobe |
| ack_level_i | input | 4 | Level being acknowledged |
| irq_level_o | output | 4 | Level of the winning request, 0 for none |
| trap_type_o | output | 8 | Trap type of the winning request |

## Verification
Several properties are checked on every cycle: edge capture, clearing by acknowledge and by the clear register, and the two facts about the encoder output. The encoder output must be an active source, and no higher-numbered source may be active. The assertions also check that the trap type tracks the level and that bit 0 stays quiet. Other behaviours only show up across a sequence of events, so only the directed scenarios can show them. These are: a line held high staying cleared after a clear, pending being read-only, an acknowledge of level 0 having no effect, disabled sources dropping out of arbitration, and an edge that coincides with a clear or an acknowledge winning over it.

// File: rtl/prio_irq_pkg.sv
// Shared constants for the prioritized interrupt controller.
package prio_irq_pkg;
    // Word selects taken from byte-offset bits [3:2]; order is fixed by the register layout
    typedef enum logic [1:0] {
        REG_ENABLE  = 2'd0,
        REG_PENDING = 2'd1,
        REG_FORCE   = 2'd2,
        REG_CLEAR   = 2'd3
    } reg_sel_e;

    localparam int unsigned TRAP_OFFSET = 32'h10;
endpackage

// File: rtl/irq_src_cell.sv
// One interrupt source: edge detector, pending flag, force flag and enable flag.
// Assumes the clear and acknowledge hits are already decoded for this source.
// A new edge wins over clear/ack; a force write wins over clear/ack.
module irq_src_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic en_we_i,
    input  logic en_d_i,
    input  logic frc_we_i,
    input  logic frc_d_i,
    input  logic clr_hit_i,
    input  logic ack_hit_i,
    output logic pend_o,
    output logic frc_o,
    output logic en_o,
    output logic active_o
);
    logic req_q;
    logic pend_q;
    logic frc_q;
    logic en_q;
    logic rise;
    logic drop;

    // Rising edge of the request line and whether this source is being retired
    always_comb begin
        rise = req_i & ~req_q;
        drop = clr_hit_i | ack_hit_i;
    end

    // Register the line, the pending, force and enable flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= 1'b0;
            pend_q <= 1'b0;
            frc_q  <= 1'b0;
            en_q   <= 1'b0;
        end else begin
            req_q  <= req_i;
            pend_q <= rise | (pend_q & ~drop);
            if (frc_we_i)
                frc_q <= frc_d_i;
            else if (drop)
                frc_q <= 1'b0;
            if (en_we_i)
                en_q <= en_d_i;
        end
    end

    // Source requests when enabled and either pending or forced
    always_comb begin
        pend_o   = pend_q;
        frc_o    = frc_q;
        en_o     = en_q;
        active_o = (pend_q | frc_q) & en_q;
    end

    AST_EDGE_SETS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !req_q) |=> pend_q); // R2

    AST_ACK_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_hit_i && !rise && !frc_we_i) |=> (!pend_q && !frc_q)); // R9

    AST_CLEAR_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit_i && !rise && !frc_we_i) |=> (!pend_q && !frc_q)); // R5
endmodule

// File: rtl/irq_prio_enc.sv
// Fixed-priority encoder: returns the index of the highest set bit, 0 if none.
// Assumes bit 0 of the input is never set by the caller.
module irq_prio_enc #(
    parameter int unsigned NSRC  = 16,
    parameter int unsigned LVL_W = $clog2(NSRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  active_i,
    output logic [LVL_W-1:0] level_o
);
    // Scan upward so the last (highest) active index wins
    always_comb begin
        level_o = '0;
        for (int i = 1; i < int'(NSRC); i++) begin
            if (active_i[i])
                level_o = LVL_W'(i);
        end
    end

    AST_WINNER_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (level_o != '0) |-> active_i[level_o]); // R7

    AST_NO_HIGHER_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ((active_i >> level_o) >> 1) == '0); // R7
endmodule

// File: rtl/irq_reg_if.sv
// Register bus decode: write strobes for enable/force/clear and the read mux.
// Assumes single-cycle accesses; reads are combinational from the flag vectors.
module irq_reg_if
    import prio_irq_pkg::*;
#(
    parameter int unsigned NSRC   = 16,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [NSRC-1:0]   en_v_i,
    input  logic [NSRC-1:0]   pend_v_i,
    input  logic [NSRC-1:0]   frc_v_i,
    output logic              en_we_o,
    output logic              frc_we_o,
    output logic              clr_we_o,
    output logic [DATA_W-1:0] rdata_o
);
    reg_sel_e word;

    // Pick the word register from the byte offset
    always_comb word = reg_sel_e'(addr_i[3:2]);

    // Write strobes; the pending word has none, which keeps it read-only
    always_comb begin
        en_we_o  = sel_i & wr_i & (word == REG_ENABLE);
        frc_we_o = sel_i & wr_i & (word == REG_FORCE);
        clr_we_o = sel_i & wr_i & (word == REG_CLEAR);
    end

    // Read mux; the clear word always reads zero
    always_comb begin
        rdata_o = '0;
        if (sel_i && !wr_i) begin
            unique case (word)
                REG_ENABLE:  rdata_o = DATA_W'(en_v_i);
                REG_PENDING: rdata_o = DATA_W'(pend_v_i);
                REG_FORCE:   rdata_o = DATA_W'(frc_v_i);
                REG_CLEAR:   rdata_o = '0;
                default:     rdata_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
// Top of the prioritized interrupt controller. Instantiates one source cell per
// usable source (bit 0 tied off), the register decode and the priority encoder.
// Assumes the acknowledge level is only meaningful while ack_i is high.
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int unsigned NSRC   = 16,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned TRAP_W = 8,
    parameter int unsigned LVL_W  = $clog2(NSRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   req_i,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic              ack_i,
    input  logic [LVL_W-1:0]  ack_level_i,
    output logic [LVL_W-1:0]  irq_level_o,
    output logic [TRAP_W-1:0] trap_type_o
);
    logic [NSRC-1:0] en_v;
    logic [NSRC-1:0] pend_v;
    logic [NSRC-1:0] frc_v;
    logic [NSRC-1:0] active_v;
    logic            en_we;
    logic            frc_we;
    logic            clr_we;
    logic [LVL_W-1:0] level;

    irq_reg_if #(
        .NSRC  (NSRC),
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W)
    ) u_regs (
        .sel_i   (bus_sel_i),
        .wr_i    (bus_wr_i),
        .addr_i  (bus_addr_i),
        .en_v_i  (en_v),
        .pend_v_i(pend_v),
        .frc_v_i (frc_v),
        .en_we_o (en_we),
        .frc_we_o(frc_we),
        .clr_we_o(clr_we),
        .rdata_o (bus_rdata_o)
    );

    for (genvar g = 0; g < int'(NSRC); g++) begin : g_src
        if (g == 0) begin : g_unused
            // Source 0 does not exist: tie every flag low
            always_comb begin
                en_v[g]     = 1'b0;
                pend_v[g]   = 1'b0;
                frc_v[g]    = 1'b0;
                active_v[g] = 1'b0;
            end
        end else begin : g_cell
            logic clr_hit;
            logic ack_hit;

            // Decode the clear and acknowledge hits for this source
            always_comb begin
                clr_hit = clr_we & bus_wdata_i[g];
                ack_hit = ack_i & (ack_level_i == LVL_W'(g));
            end

            irq_src_cell u_cell (
                .clk      (clk),
                .rst_n    (rst_n),
                .req_i    (req_i[g]),
                .en_we_i  (en_we),
                .en_d_i   (bus_wdata_i[g]),
                .frc_we_i (frc_we),
                .frc_d_i  (bus_wdata_i[g]),
                .clr_hit_i(clr_hit),
                .ack_hit_i(ack_hit),
                .pend_o   (pend_v[g]),
                .frc_o    (frc_v[g]),
                .en_o     (en_v[g]),
                .active_o (active_v[g])
            );
        end
    end

    irq_prio_enc #(
        .NSRC (NSRC),
        .LVL_W(LVL_W)
    ) u_enc (
        .clk     (clk),
        .rst_n   (rst_n),
        .active_i(active_v),
        .level_o (level)
    );

    // Present the level and its trap type; no request gives trap type 0
    always_comb begin
        irq_level_o = level;
        if (level == '0)
            trap_type_o = '0;
        else
            trap_type_o = TRAP_W'(TRAP_OFFSET) + TRAP_W'(level);
    end

    AST_TRAP_TRACKS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_type_o == '0) == (irq_level_o == '0)); // R8

    AST_BIT0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_v[0] && !frc_v[0] && !en_v[0]); // R11
endmodule

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] req_i = '0;
    logic        bus_sel_i = 1'b0;
    logic        bus_wr_i = 1'b0;
    logic [3:0]  bus_addr_i = '0;
    logic [31:0] bus_wdata_i = '0;
    logic [31:0] bus_rdata_o;
    logic        ack_i = 1'b0;
    logic [3:0]  ack_level_i = '0;
    logic [3:0]  irq_level_o;
    logic [7:0]  trap_type_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk; // 50 MHz

    prio_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i),
        .bus_sel_i(bus_sel_i), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
        .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
        .ack_i(ack_i), .ack_level_i(ack_level_i),
        .irq_level_o(irq_level_o), .trap_type_o(trap_type_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel_i = 1'b1; bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk);
        bus_sel_i = 1'b0; bus_wr_i = 1'b0; bus_wdata_i = '0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel_i = 1'b1; bus_wr_i = 1'b0; bus_addr_i = a;
        #1 d = bus_rdata_o;
        @(negedge clk);
        bus_sel_i = 1'b0;
    endtask

    task automatic pulse(input int n);
        @(negedge clk);
        req_i[n] = 1'b1;
        @(negedge clk);
        req_i[n] = 1'b0;
    endtask

    task automatic ack(input logic [3:0] lv);
        @(negedge clk);
        ack_i = 1'b1; ack_level_i = lv;
        @(negedge clk);
        ack_i = 1'b0; ack_level_i = '0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        bus_rd(4'h0, d); chk("R1 enable", d, 32'h0);
        bus_rd(4'h4, d); chk("R1 pending", d, 32'h0);
        bus_rd(4'h8, d); chk("R1 force", d, 32'h0);
        chk("R1 level", 32'(irq_level_o), 32'h0);
        chk("R1 trap", 32'(trap_type_o), 32'h0);
    endtask

    task automatic t_edge_enable;
        logic [31:0] d;
        pulse(5);
        bus_rd(4'h4, d); chk("R2 pending after edge", d, 32'h20);
        chk("R3 disabled source no level", 32'(irq_level_o), 32'h0);
        bus_wr(4'h0, 32'hFFFF_FFFF);
        bus_rd(4'h0, d); chk("R3 enable readback", d, 32'h0000_FFFE);
        chk("R7 level 5", 32'(irq_level_o), 32'd5);
        chk("R8 trap 0x15", 32'(trap_type_o), 32'h15);
        @(negedge clk); req_i[6] = 1'b1;
        @(negedge clk);
        chk("R7 level 6", 32'(irq_level_o), 32'd6);
        bus_wr(4'hC, 32'h40);
        repeat (3) @(negedge clk);
        bus_rd(4'h4, d); chk("R2 held line stays cleared", d, 32'h20);
        chk("R7 back to 5", 32'(irq_level_o), 32'd5);
        req_i[6] = 1'b0;
    endtask

    task automatic t_force;
        logic [31:0] d;
        bus_wr(4'h8, 32'h8000);
        bus_rd(4'h8, d); chk("R4 force readback", d, 32'h8000);
        chk("R4 forced level 15", 32'(irq_level_o), 32'd15);
        chk("R8 trap 0x1F", 32'(trap_type_o), 32'h1F);
        bus_wr(4'h0, 32'h7FFE);
        chk("R3 masked 15 falls to 5", 32'(irq_level_o), 32'd5);
        bus_wr(4'h0, 32'hFFFE);
    endtask

    task automatic t_clear;
        logic [31:0] d;
        bus_wr(4'hC, 32'h8020);
        bus_rd(4'h4, d); chk("R5 pending cleared", d, 32'h0);
        bus_rd(4'h8, d); chk("R5 force cleared", d, 32'h0);
        bus_rd(4'hC, d); chk("R5 clear reads 0", d, 32'h0);
        chk("R7 no request", 32'(irq_level_o), 32'h0);
    endtask

    task automatic t_readonly;
        logic [31:0] d;
        bus_wr(4'h4, 32'hFFFF);
        bus_rd(4'h4, d); chk("R6 pending read-only", d, 32'h0);
        chk("R6 level unchanged", 32'(irq_level_o), 32'h0);
    endtask

    task automatic t_ack;
        logic [31:0] d;
        pulse(3); pulse(9);
        chk("R7 level 9 over 3", 32'(irq_level_o), 32'd9);
        ack(4'd9);
        bus_rd(4'h4, d); chk("R9 ack clears 9", d, 32'h008);
        chk("R9 level 3 after ack", 32'(irq_level_o), 32'd3);
        ack(4'd0);
        bus_rd(4'h4, d); chk("R9 ack level 0 ignored", d, 32'h008);
        bus_wr(4'h8, 32'h0400);
        ack(4'd10);
        bus_rd(4'h8, d); chk("R9 ack clears force", d, 32'h0);
        bus_wr(4'hC, 32'h8);
    endtask

    task automatic t_race;
        logic [31:0] d;
        @(negedge clk);
        req_i[4] = 1'b1;
        bus_sel_i = 1'b1; bus_wr_i = 1'b1; bus_addr_i = 4'hC; bus_wdata_i = 32'h10;
        @(negedge clk);
        bus_sel_i = 1'b0; bus_wr_i = 1'b0; bus_wdata_i = '0; req_i[4] = 1'b0;
        bus_rd(4'h4, d); chk("R10 edge beats clear", d, 32'h10);
        @(negedge clk);
        req_i[4] = 1'b1; ack_i = 1'b1; ack_level_i = 4'd4;
        @(negedge clk);
        req_i[4] = 1'b0; ack_i = 1'b0; ack_level_i = '0;
        bus_rd(4'h4, d); chk("R10 edge beats ack", d, 32'h10);
        bus_wr(4'hC, 32'hFFFF);
    endtask

    task automatic t_bit0;
        logic [31:0] d;
        pulse(0);
        bus_wr(4'h8, 32'h1);
        bus_rd(4'h4, d); chk("R11 line 0 ignored", d, 32'h0);
        bus_rd(4'h8, d); chk("R11 force bit 0 ignored", d, 32'h0);
        chk("R11 no level", 32'(irq_level_o), 32'h0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_edge_enable();
        t_force();
        t_clear();
        t_readonly();
        t_ack();
        t_race();
        t_bit0();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule